// File: doc/BRIEF.md
# Link Connection Handshake Controller

This block is the receiving-end controller of the connect and disconnect handshake on a point-to-point parallel channel. It registers the incoming request and interconnect lines from the remote sender once. It tells the host when a connect request is pending and whether a sender is present. It then drives the outgoing connect line according to two host inputs: a connect strobe and an accept/reject choice.

An accepted request holds the connect line high until the host drops its connect strobe. Dropping the strobe is the disconnect. A rejected request raises the connect line for a fixed number of cycles, four by default. If the host is still holding the strobe when that pulse ends, further requests are locked out. Dropping the strobe re-enables them. A two-bit mode input takes the block off-line or disables it. In either case the handshake is forced back to rest. The host can feed the request output straight back into the connect strobe, and the block then answers every request automatically. In that setup the accept/reject input works as an available/busy flag.

The state machine has four states. IDLE waits for a request. CONNECTED holds an accepted link. REJECT_PULSE drives the timed reject pulse using a small cycle counter. REJECT_LOCK blocks new requests. The transitions are:
- accept: IDLE to CONNECTED.
- reject: IDLE to REJECT_PULSE.
- disconnect: CONNECTED to IDLE.
- pulse end, strobe released: REJECT_PULSE to IDLE.
- pulse end, strobe held: REJECT_PULSE to REJECT_LOCK.
- release: REJECT_LOCK to IDLE.
- mode exit: any state to IDLE whenever the mode is not on-line.

Top module: `link_conn_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the machine in IDLE and drives `conn_out`, `conn_req` and `src_avail` low from the first clock edge with reset high.
- R2: While `host_conn` is low, `conn_out` stays low, and `conn_req` follows `req_in` one clock later (one register stage) when on-line.
- R3: In IDLE, on-line, with the registered request high and `host_conn` high, `host_accept` high selects accept: `conn_out` is high from the next clock and stays high while `host_conn` stays high.
- R4: With `host_accept` low in that same decision cycle, the block rejects: `conn_out` is high for exactly REJ_CYCLES (default 4) clocks, then low.
- R5: `host_accept` is sampled only in the decision cycle. Changing it while CONNECTED, REJECT_PULSE or REJECT_LOCK has no effect on `conn_out` or `conn_req`.
- R6: If `host_conn` is high when the reject pulse ends, the machine enters REJECT_LOCK. There `conn_out` and `conn_req` stay low while `host_conn` stays high. Dropping `host_conn` returns to IDLE, and requests are reported again.
- R7: Disconnect: `host_conn` low while CONNECTED makes `conn_out` fall on the next clock, and the machine returns to IDLE.
- R8: `conn_req` is high exactly when the registered request is high, the mode is on-line, and the machine is not in REJECT_LOCK.
- R9: `src_avail` is high exactly when the registered interconnect line is high and the mode is on-line.
- R10: Mode encoding is 2'b01 on-line, 2'b10 off-line, and 2'b00 or 2'b11 disabled. Any mode other than on-line forces `conn_out`, `conn_req` and `src_avail` low in the same cycle, and forces IDLE on the next clock.
- R11: With `conn_req` wired to `host_conn`, every request is accepted while `host_accept` is high and rejected while it is low.
- R12: If the mode leaves on-line during a reject pulse, the pulse is cut off at once. A later return to on-line starts from IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 01 on-line, 10 off-line, 00/11 disabled |
| req_in | input | 1 | Incoming request line from the sender |
| icon_in | input | 1 | Incoming interconnect line from the sender |
| host_conn | input | 1 | Host connect strobe; low means disconnect or release |
| host_accept | input | 1 | High accepts, low rejects; used in the decision cycle only |
| conn_out | output | 1 | Outgoing connect line to the sender |
| conn_req | output | 1 | Pending connect request reported to the host |
| src_avail | output | 1 | Sender present while on-line |

## Verification
Two functions can act in the same cycle: the mode-driven forced return to rest, and an active reject pulse or held connection. The bench leaves on-line in the middle of a reject pulse and also while CONNECTED. A behavioural reference model, compared on every clock, judges whether `conn_out` falls in that same cycle and whether the machine restarts from IDLE when on-line returns. A second overlap is tested in the automatic loop-back setup. There the request output is itself the connect strobe, so the lockout release and the next decision follow each other directly. The bench checks that each new request gets a full pulse again.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE         = 2'b00,
        ST_CONNECTED    = 2'b01,
        ST_REJECT_PULSE = 2'b10,
        ST_REJECT_LOCK  = 2'b11
    } lcc_state_t;

    localparam logic [1:0] MODE_ONLINE = 2'b01;

endpackage

// File: rtl/lcc_in_reg.sv
module lcc_in_reg #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // one flop per incoming line; lines are already synchronous
    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) q[g] <= 1'b0;
            else     q[g] <= d[g];
        end
    end
endmodule

// File: rtl/lcc_fsm.sv
module lcc_fsm
    import lcc_pkg::*;
#(
    parameter int REJ_CYCLES = 4,
    localparam int CW = (REJ_CYCLES > 1) ? $clog2(REJ_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          online,
    input  logic          req_q,
    input  logic          host_conn,
    input  logic          host_accept,
    output lcc_state_t    state,
    output logic [CW-1:0] cnt
);
    localparam logic [CW-1:0] CNT_LAST = CW'(REJ_CYCLES - 1);

    lcc_state_t    state_nx;
    logic [CW-1:0] cnt_nx;

    always_comb begin
        state_nx = state;
        cnt_nx   = cnt;
        if (!online) begin
            state_nx = ST_IDLE;
            cnt_nx   = '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (host_conn && req_q) begin
                        cnt_nx   = '0;
                        state_nx = host_accept ? ST_CONNECTED : ST_REJECT_PULSE;
                    end
                end
                ST_CONNECTED: begin
                    if (!host_conn) state_nx = ST_IDLE;
                end
                ST_REJECT_PULSE: begin
                    if (cnt == CNT_LAST) begin
                        cnt_nx   = '0;
                        state_nx = host_conn ? ST_REJECT_LOCK : ST_IDLE;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                ST_REJECT_LOCK: begin
                    if (!host_conn) state_nx = ST_IDLE;
                end
                default: state_nx = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_nx;
            cnt   <= cnt_nx;
        end
    end

    assert_accept_hold_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONNECTED && host_conn && online) |=> state == ST_CONNECTED);

    assert_pulse_step_R4: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJECT_PULSE && cnt != CNT_LAST && online)
        |=> (state == ST_REJECT_PULSE && cnt == CW'($past(cnt) + 1'b1)));

    assert_lock_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_REJECT_LOCK && host_conn && online) |=> state == ST_REJECT_LOCK);

    assert_disconnect_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_CONNECTED && !host_conn) |=> state == ST_IDLE);

    assert_mode_idle_R10: assert property (@(posedge clk) disable iff (rst)
        !online |=> state == ST_IDLE);
endmodule

// File: rtl/lcc_out.sv
module lcc_out
    import lcc_pkg::*;
(
    input  logic       online,
    input  lcc_state_t state,
    input  logic       req_q,
    input  logic       icon_q,
    output logic       conn_out,
    output logic       conn_req,
    output logic       src_avail
);
    always_comb begin
        conn_out  = 1'b0;
        conn_req  = 1'b0;
        src_avail = online && icon_q;
        if (online) begin
            unique case (state)
                ST_IDLE: begin
                    conn_req = req_q;
                end
                ST_CONNECTED, ST_REJECT_PULSE: begin
                    conn_out = 1'b1;
                    conn_req = req_q;
                end
                ST_REJECT_LOCK: begin
                    conn_req = 1'b0;
                end
                default: conn_out = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/link_conn_ctrl.sv
module link_conn_ctrl
    import lcc_pkg::*;
#(
    parameter int REJ_CYCLES = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode,
    input  logic       req_in,
    input  logic       icon_in,
    input  logic       host_conn,
    input  logic       host_accept,
    output logic       conn_out,
    output logic       conn_req,
    output logic       src_avail
);
    localparam int CW = (REJ_CYCLES > 1) ? $clog2(REJ_CYCLES) : 1;

    logic [1:0]    line_q;
    lcc_state_t    state;
    logic [CW-1:0] cnt;
    logic          online;

    assign online = (mode == MODE_ONLINE);

    lcc_in_reg #(.W(2)) u_in (
        .clk (clk),
        .rst (rst),
        .d   ({icon_in, req_in}),
        .q   (line_q)
    );

    lcc_fsm #(.REJ_CYCLES(REJ_CYCLES)) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .online      (online),
        .req_q       (line_q[0]),
        .host_conn   (host_conn),
        .host_accept (host_accept),
        .state       (state),
        .cnt         (cnt)
    );

    lcc_out u_out (
        .online    (online),
        .state     (state),
        .req_q     (line_q[0]),
        .icon_q    (line_q[1]),
        .conn_out  (conn_out),
        .conn_req  (conn_req),
        .src_avail (src_avail)
    );

    assert_offline_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (mode != MODE_ONLINE) |-> (!conn_out && !conn_req && !src_avail));

    assert_idle_no_conn_R2: assert property (@(posedge clk) disable iff (rst)
        (!host_conn && state == ST_IDLE) |=> !($past(state) == ST_IDLE && conn_out));

    assert_req_source_R8: assert property (@(posedge clk) disable iff (rst)
        conn_req |-> $past(req_in));
endmodule

// File: tb/link_conn_ctrl_bench.sv
`timescale 1ns/100ps
module link_conn_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] mode = 2'b01;
    logic       req_drv = 1'b0, icon_drv = 1'b0, host_drv = 1'b0, acc_drv = 1'b0;
    logic       auto_tie = 1'b0;
    logic       host_conn, conn_out, conn_req, src_avail;

    int n_cmp = 0, n_bad = 0, cycles = 0;
    bit run = 1'b0, done = 1'b0;
    string tag = "R1";

    // model state: 0 idle, 1 connected, 2 pulse, 3 lock
    int  ph = 0, left = 0;
    bit  mr = 1'b0, mi = 1'b0;

    always #2.5 clk = ~clk;

    assign host_conn = auto_tie ? conn_req : host_drv;

    link_conn_ctrl u_link_conn_ctrl (
        .clk(clk), .rst(rst), .mode(mode), .req_in(req_drv), .icon_in(icon_drv),
        .host_conn(host_conn), .host_accept(acc_drv),
        .conn_out(conn_out), .conn_req(conn_req), .src_avail(src_avail)
    );

    function automatic bit m_on(); return mode == 2'b01; endfunction
    function automatic bit m_creq(); return m_on() && mr && ph != 3; endfunction

    always @(posedge clk) begin
        cycles++;
        if (rst) begin
            ph = 0; left = 0; mr = 1'b0; mi = 1'b0; run = 1'b1;
        end else begin
            bit hc;
            hc = auto_tie ? m_creq() : host_drv;
            if (!m_on()) begin
                ph = 0; left = 0;
            end else begin
                case (ph)
                    0: if (hc && mr) begin
                           if (acc_drv) ph = 1;
                           else begin ph = 2; left = 4; end
                       end
                    1: if (!hc) ph = 0;
                    2: begin
                           left--;
                           if (left == 0) ph = hc ? 3 : 0;
                       end
                    default: if (!hc) ph = 0;
                endcase
            end
            mr = req_drv; mi = icon_drv;
        end
        if (cycles > 20000 && !done) begin
            n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected<=20000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(bit ok, string t, int act, int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", t, $time, act, exp);
        end
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (run) begin
            bit e_conn;
            e_conn = m_on() && (ph == 1 || ph == 2);
            chk(conn_out == e_conn, {tag, " conn_out"}, conn_out, e_conn);
            chk(conn_req == m_creq(), {tag, " conn_req"}, conn_req, m_creq());
            chk(src_avail == (m_on() && mi), {tag, " src_avail"}, src_avail, m_on() && mi);
        end
    end

    task automatic step(int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    initial begin
        int hi;
        step(2);
        // R1 reset state
        chk(conn_out == 0 && conn_req == 0 && src_avail == 0, "R1 reset outputs",
            {conn_out, conn_req, src_avail}, 0);
        rst = 1'b0; step(1);

        // R2 / R8: request follows line with host strobe low
        tag = "R2";
        req_drv = 1; step(1); req_drv = 0; step(1); req_drv = 1; step(3);
        tag = "R8"; req_drv = 0; step(2);
        // R9 interconnect
        tag = "R9"; icon_drv = 1; step(3); icon_drv = 0; step(2); icon_drv = 1; step(1);

        // R3 accept, R5 accept input ignored, R7 disconnect
        tag = "R3"; req_drv = 1; step(1);
        acc_drv = 1; host_drv = 1; step(1);
        tag = "R5"; acc_drv = 0; step(6);
        chk(conn_out == 1, "R3 connection held", conn_out, 1);
        tag = "R7"; host_drv = 0; step(1);
        chk(conn_out == 0, "R7 disconnect next clock", conn_out, 0);
        step(2);

        // R4 reject pulse, R6 lockout while held
        tag = "R4"; acc_drv = 0; host_drv = 1;
        hi = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); if (conn_out) hi++;
            if (k == 5) acc_drv = 1;   // R5 ignored during pulse/lock
        end
        chk(hi == 4, "R4 reject pulse length", hi, 4);
        tag = "R6"; step(1);
        chk(conn_req == 0, "R6 lockout hides request", conn_req, 0);
        host_drv = 0; step(2);
        chk(conn_req == 1, "R6 release re-enables", conn_req, 1);

        // reject with strobe dropped during pulse
        tag = "R4"; acc_drv = 0; host_drv = 1; step(2); host_drv = 0; step(6);

        // R10 modes while connected
        tag = "R10"; acc_drv = 1; host_drv = 1; step(3);
        mode = 2'b10; step(1);
        chk(conn_out == 0 && src_avail == 0, "R10 off-line quiet", conn_out, 0);
        mode = 2'b00; step(2); mode = 2'b11; step(2);
        host_drv = 0; mode = 2'b01; step(2);

        // R12 mode exit in the middle of a reject pulse
        tag = "R12"; acc_drv = 0; host_drv = 1; step(3);
        mode = 2'b10; step(1);
        chk(conn_out == 0, "R12 pulse cut", conn_out, 0);
        host_drv = 0; mode = 2'b01; step(3);

        // R11 automatic loop-back
        tag = "R11"; req_drv = 0; step(2); auto_tie = 1; acc_drv = 1;
        req_drv = 1; step(6);
        chk(conn_out == 1, "R11 auto accept", conn_out, 1);
        req_drv = 0; step(4);
        acc_drv = 0; req_drv = 1;
        hi = 0;
        for (int k = 0; k < 12; k++) begin @(negedge clk); if (conn_out) hi++; end
        chk(hi >= 4, "R11 auto reject pulses", hi, 4);
        req_drv = 0; auto_tie = 0; step(4);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule